// File: doc/BRIEF.md
# Processing Element Layer Sequencer

This block lives inside one processing element of a coarse-grained array. It decides which stored configuration word drives the element's operator and routing selects on each cycle. The configuration loader can preload up to three layers, called start, middle and end. Each layer holds a 16-bit configuration word and a 10-bit repeat count. After a start strobe, the sequencer steps through the layers that hold work, in that fixed order. Each layer stays active for its programmed number of enabled cycles. When the last layer finishes, the block reports completion.

A PE reset wipes every stored layer, so nothing from a previously mapped module can run by mistake. While the sequencer is idle it drives an all-zero configuration. A loader write that arrives during a run is refused and raises a sticky error flag. The arithmetic datapath that consumes the configuration is not part of this block.

Top module: `pe_layer_seq`

## Requirements
- R1: Layers with work run in the fixed order start (layer code 0), middle (code 1), end (code 2); `cfg_out` shows the active layer's stored word from the cycle after the accepted start.
- R2: Each layer stays active for exactly its 10-bit count of cycles with `step_en` high (1 to 1023).
- R3: A cycle with `step_en` low does not count, and `cfg_out` holds its value across it.
- R4: A layer that was not written since reset is skipped.
- R5: A layer written with a count of zero is skipped.
- R6: After the final enabled cycle of the last layer with work, `done` is high for exactly one cycle, and `cfg_out` is all zeros whenever no run is active.
- R7: If no layer holds work, a start makes `done` high on the cycle after it is sampled.
- R8: A start strobe during a run is ignored; the run continues unchanged and completes with a single `done` pulse.
- R9: A layer write during a run leaves the stored layers unchanged and sets `wr_err` from the next cycle; `wr_err` stays high until reset.
- R10: A synchronous reset clears all stored layers, `done` and `wr_err`; a start after reset behaves as R7.
- R11: A write with layer code 3 stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high PE reset; clears all layers |
| wr_en | input | 1 | Layer write strobe from the loader |
| wr_sel | input | 2 | Layer code: 0 start, 1 middle, 2 end, 3 no layer |
| wr_cfg | input | 16 | Configuration word to store |
| wr_cnt | input | 10 | Repeat count to store |
| start | input | 1 | Begin a run through the stored layers |
| step_en | input | 1 | Cycle enable; only enabled cycles count |
| cfg_out | output | 16 | Active configuration word, zero when idle |
| done | output | 1 | One-cycle completion pulse |
| wr_err | output | 1 | Sticky flag: a write was attempted during a run |

## Verification
The assertions check several behaviours on every cycle: the held configuration across stalled cycles, the single-cycle width of `done`, completion whenever a run ends, the setting and stickiness of `wr_err`, the way a start during a run is ignored, and the cleared outputs after reset. The layer order, the exact number of enabled cycles per layer, the skipping of unwritten, zero-count or code-3 layers, and the immediate completion of an empty start depend on what was loaded. Only the bench's scenarios can show these, by comparing `cfg_out` cycle by cycle against a sequence it computes from the loaded counts.

// File: rtl/pe_layer_pkg.sv
package pe_layer_pkg;
    localparam int CFG_W    = 16;
    localparam int CNT_W    = 10;
    localparam int N_LAYERS = 3;
    localparam int IDX_W    = $clog2(N_LAYERS + 1);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] sel;
        logic [CFG_W-1:0] cfg;
        logic [CNT_W-1:0] cnt;
    } layer_wr_t;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } layer_pick_t;

    // Lowest eligible layer, either anywhere or strictly after cur.
    function automatic layer_pick_t pick_layer(
        input logic [N_LAYERS-1:0] elig,
        input logic [IDX_W-1:0]    cur,
        input logic                from_first
    );
        layer_pick_t res;
        res = '0;
        for (int i = N_LAYERS - 1; i >= 0; i--) begin
            if (elig[i] && (from_first || (IDX_W'(i) > cur))) begin
                res.found = 1'b1;
                res.idx   = IDX_W'(i);
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/pe_layer_bank.sv
module pe_layer_bank
    import pe_layer_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  layer_wr_t                        wr,
    input  logic                             wr_allow,
    output logic [N_LAYERS-1:0][CFG_W-1:0]   cfg_q,
    output logic [N_LAYERS-1:0][CNT_W-1:0]   cnt_q,
    output logic [N_LAYERS-1:0]              elig
);
    logic [N_LAYERS-1:0] valid_q;

    for (genvar g = 0; g < N_LAYERS; g++) begin : g_layer
        logic hit;
        assign hit = wr.en && wr_allow && (wr.sel == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
                cfg_q[g]   <= '0;
                cnt_q[g]   <= '0;
            end else if (hit) begin
                valid_q[g] <= 1'b1;
                cfg_q[g]   <= wr.cfg;
                cnt_q[g]   <= wr.cnt;
            end
        end

        assign elig[g] = valid_q[g] && (cnt_q[g] != '0);
    end
endmodule

// File: rtl/pe_layer_iter.sv
module pe_layer_iter
    import pe_layer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (dec) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign last = (rem_q == CNT_W'(1));
endmodule

// File: rtl/pe_layer_seq.sv
module pe_layer_seq
    import pe_layer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [15:0]      wr_cfg,
    input  logic [9:0]       wr_cnt,
    input  logic             start,
    input  logic             step_en,
    output logic [15:0]      cfg_out,
    output logic             done,
    output logic             wr_err
);
    seq_state_e                    state_q;
    logic [IDX_W-1:0]              cur_q;
    logic                          done_q;
    logic                          err_q;
    logic                          running;
    layer_wr_t                     wr;
    logic [N_LAYERS-1:0][CFG_W-1:0] cfg_q;
    logic [N_LAYERS-1:0][CNT_W-1:0] cnt_q;
    logic [N_LAYERS-1:0]           elig;
    layer_pick_t                   first_pick;
    layer_pick_t                   next_pick;
    logic                          last;
    logic                          begin_run;
    logic                          advance;
    logic                          it_load;
    logic                          it_dec;
    logic [CNT_W-1:0]              it_val;

    assign running = (state_q == ST_RUN);

    assign wr.en  = wr_en;
    assign wr.sel = IDX_W'(wr_sel);
    assign wr.cfg = CFG_W'(wr_cfg);
    assign wr.cnt = CNT_W'(wr_cnt);

    pe_layer_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .wr_allow (!running),
        .cfg_q    (cfg_q),
        .cnt_q    (cnt_q),
        .elig     (elig)
    );

    assign first_pick = pick_layer(elig, '0, 1'b1);
    assign next_pick  = pick_layer(elig, cur_q, 1'b0);

    assign begin_run = !running && start && first_pick.found;
    assign advance   = running && step_en && last;
    assign it_load   = begin_run || (advance && next_pick.found);
    assign it_dec    = running && step_en && !last;
    assign it_val    = begin_run ? cnt_q[first_pick.idx] : cnt_q[next_pick.idx];

    pe_layer_iter u_iter (
        .clk      (clk),
        .rst      (rst),
        .load     (it_load),
        .load_val (it_val),
        .dec      (it_dec),
        .last     (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!running && start) begin
                if (first_pick.found) begin
                    state_q <= ST_RUN;
                    cur_q   <= first_pick.idx;
                end else begin
                    done_q <= 1'b1;
                end
            end
            if (advance) begin
                if (next_pick.found) begin
                    cur_q <= next_pick.idx;
                end else begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
            if (running && wr_en) begin
                err_q <= 1'b1;
            end
        end
    end

    assign cfg_out = running ? 16'(cfg_q[cur_q]) : '0;
    assign done    = done_q;
    assign wr_err  = err_q;
endmodule

// File: rtl/pe_layer_seq_chk.sv
module pe_layer_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        start,
    input logic        step_en,
    input logic        running,
    input logic [15:0] cfg_out,
    input logic        done,
    input logic        wr_err
);
    // R3: a stalled cycle keeps the run going with the same word
    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (running && !step_en) |=> (running && $stable(cfg_out)));

    // R6: done lasts one cycle unless a fresh start is taken
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    // R6: every end of a run is reported
    assert_end_reports_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> done);

    // R8: a start seen while running does not end or restart the run
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (running && start && !step_en) |=> running);

    // R9: a write during a run raises the error flag
    assert_err_set_R9: assert property (@(posedge clk) disable iff (rst)
        (running && wr_en) |=> wr_err);

    // R9: the error flag stays until reset
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> wr_err);

    // R10: reset leaves every output in its idle value
    assert_rst_clear_R10: assert property (@(posedge clk)
        rst |=> (!done && !wr_err && cfg_out == 16'h0000));
endmodule

bind pe_layer_seq pe_layer_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .start   (start),
    .step_en (step_en),
    .running (running),
    .cfg_out (cfg_out),
    .done    (done),
    .wr_err  (wr_err)
);

// File: tb/pe_layer_seq_bench.sv
module pe_layer_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_cfg = '0;
    logic [9:0]  wr_cnt = '0;
    logic        start = 1'b0;
    logic        step_en = 1'b0;
    logic [15:0] cfg_out;
    logic        done;
    logic        wr_err;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pe_layer_seq u_pe_layer_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_cfg  (wr_cfg),
        .wr_cnt  (wr_cnt),
        .start   (start),
        .step_en (step_en),
        .cfg_out (cfg_out),
        .done    (done),
        .wr_err  (wr_err)
    );

    // {stall, written mask (bit i = layer code i), count0, count1, count2}
    localparam logic [33:0] VEC [0:7] = '{
        {1'b0, 3'b111, 10'd2,    10'd3, 10'd1},  // R1 R2 all layers
        {1'b1, 3'b111, 10'd1,    10'd1, 10'd1},  // R3 stalls
        {1'b0, 3'b101, 10'd2,    10'd9, 10'd3},  // R4 middle unwritten
        {1'b0, 3'b111, 10'd3,    10'd0, 10'd2},  // R5 middle zero
        {1'b0, 3'b011, 10'd0,    10'd4, 10'd5},  // R4 R5 start zero, end unwritten
        {1'b0, 3'b000, 10'd1,    10'd1, 10'd1},  // R7 nothing loaded
        {1'b1, 3'b100, 10'd0,    10'd0, 10'd4},  // R1 R3 end layer only
        {1'b0, 3'b111, 10'd1023, 10'd1, 10'd0}   // R2 maximum count
    };

    function automatic logic [15:0] exp_cfg(int v, int l);
        return 16'hC000 | 16'(v << 4) | 16'(l);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_write(logic [1:0] sel, logic [15:0] cfg, logic [9:0] cnt);
        @(negedge clk);
        wr_en  = 1'b1;
        wr_sel = sel;
        wr_cfg = cfg;
        wr_cnt = cnt;
        @(negedge clk);
        wr_en  = 1'b0;
    endtask

    task automatic run_seq(int v, logic [2:0] mask, int c0, int c1, int c2, bit stall);
        int cnt [3];
        cnt[0] = c0; cnt[1] = c1; cnt[2] = c2;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int l = 0; l < 3; l++) begin
            if (mask[l] && cnt[l] != 0) begin
                for (int k = 0; k < cnt[l]; k++) begin
                    if (stall) begin
                        step_en = 1'b0;
                        chk(cfg_out == exp_cfg(v, l), "R3 stall hold", cfg_out, exp_cfg(v, l));
                        @(negedge clk);
                    end
                    step_en = 1'b1;
                    chk(cfg_out == exp_cfg(v, l) && !done, "R1/R2 layer word",
                        {done, 15'd0, cfg_out}, {16'd0, exp_cfg(v, l)});
                    @(negedge clk);
                end
            end
        end
        step_en = 1'b0;
        chk(done == 1'b1, "R6/R7 done after last layer", done, 1);
        chk(cfg_out == 16'h0, "R6 idle config zero", cfg_out, 0);
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R10 reset state
        chk(cfg_out == 16'h0 && !done && !wr_err, "R10 reset state",
            {wr_err, done, cfg_out}, 0);

        for (int v = 0; v < 8; v++) begin
            logic [2:0] m;
            int c [3];
            m    = VEC[v][32:30];
            c[0] = int'(VEC[v][29:20]);
            c[1] = int'(VEC[v][19:10]);
            c[2] = int'(VEC[v][9:0]);
            do_reset();
            for (int l = 0; l < 3; l++) begin
                if (m[l]) do_write(2'(l), exp_cfg(v, l), 10'(c[l]));
            end
            run_seq(v, m, c[0], c[1], c[2], VEC[v][33]);
        end

        // R10: reset wipes loaded layers
        do_reset();
        do_write(2'd0, exp_cfg(10, 0), 10'd2);
        do_reset();
        run_seq(10, 3'b000, 0, 0, 0, 1'b0);

        // R11: layer code 3 stores nothing
        do_reset();
        do_write(2'd3, exp_cfg(11, 3), 10'd5);
        run_seq(11, 3'b000, 0, 0, 0, 1'b0);

        // R8 and R9: start and write during a run
        do_reset();
        do_write(2'd0, exp_cfg(15, 0), 10'd4);
        do_write(2'd2, exp_cfg(15, 2), 10'd2);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);                     // run began
        start = 1'b0;
        step_en = 1'b1;
        chk(cfg_out == exp_cfg(15, 0), "R8 first word", cfg_out, exp_cfg(15, 0));
        @(negedge clk);                     // one counted
        start  = 1'b1;
        wr_en  = 1'b1;
        wr_sel = 2'd0;
        wr_cfg = 16'h5A5A;
        wr_cnt = 10'd1;
        chk(cfg_out == exp_cfg(15, 0), "R8 before second start", cfg_out, exp_cfg(15, 0));
        @(negedge clk);                     // two counted
        start = 1'b0;
        wr_en = 1'b0;
        chk(wr_err == 1'b1, "R9 error raised", wr_err, 1);
        chk(cfg_out == exp_cfg(15, 0), "R8 run unchanged", cfg_out, exp_cfg(15, 0));
        @(negedge clk);                     // three counted
        chk(cfg_out == exp_cfg(15, 0), "R8 start layer length", cfg_out, exp_cfg(15, 0));
        @(negedge clk);
        chk(cfg_out == exp_cfg(15, 2), "R8 end layer", cfg_out, exp_cfg(15, 2));
        @(negedge clk);
        chk(cfg_out == exp_cfg(15, 2), "R8 end layer length", cfg_out, exp_cfg(15, 2));
        @(negedge clk);
        step_en = 1'b0;
        chk(done == 1'b1, "R8 single completion", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R8 no second done", done, 0);
        chk(wr_err == 1'b1, "R9 error sticky", wr_err, 1);
        // R9: the refused write left layer 0 intact
        run_seq(15, 3'b101, 4, 0, 2, 1'b0);
        do_reset();
        @(negedge clk);
        chk(wr_err == 1'b0, "R10 reset clears error", wr_err, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule